// File: doc/BRIEF.md
# I2C Register-Access Slave Front-End

This block is the bus-side controller of a small I2C peripheral. It takes SCL and SDA levels that have already been synchronized and filtered, recognizes START and STOP conditions, and answers at a 7-bit slave address whose upper six bits are fixed at `010000`. The least significant address bit is taken from a strapping input, so two of these devices can share one bus.

The first byte after a write-addressed header is captured into a pointer, which selects the internal register. Any further bytes in the same write transfer are written to that register through a simple register-bus port. To read, the master first sets the pointer with a write transfer. It then issues a repeated START and addresses the device with the read bit set. The block then shifts out register data, one byte per master acknowledge, and strobes the register bus each time it loads a byte.

The block drives the bus only by pulling SDA low through an open-drain enable. The active-low reset input returns the bus logic and the pointer to their initial state at any time.

Top module: `i2c_regbus_slave`

## Requirements
- R1: While `rst_ni` is low, and after its release with no bus activity, `sda_oe_o`, `reg_we_o` and `reg_re_o` are 0 and `reg_addr_o` is 0x00.
- R2: An address byte whose upper seven bits equal `{6'b010000, addr_strap_i}` is acknowledged: `sda_oe_o` is 1 while SCL is high during the ninth clock.
- R3: Any other address byte gets no acknowledge. Every byte after it, up to the next START, is ignored: no acknowledge, no strobe, and `reg_addr_o` unchanged.
- R4: The first byte after an acknowledged write address (bit 0 = 0) is acknowledged and appears on `reg_addr_o`.
- R5: Each further byte of a write transfer is acknowledged. Each gives exactly one `reg_we_o` pulse, with the byte on `reg_wdata_o`, and `reg_we_o` is high only while the acknowledge is being driven. The pointer does not change.
- R6: After a repeated START and an acknowledged read address (bit 0 = 1), each data byte is `reg_rdata_i` sampled at the pointer, sent MSB first. A 0 bit is sent by `sda_oe_o` = 1 and a 1 bit by releasing SDA. One `reg_re_o` pulse is issued when each byte is loaded.
- R7: A master acknowledge (SDA low on the ninth clock) after a read byte makes the block send another byte. A master not-acknowledge ends the data phase: SDA stays released and no further `reg_re_o` pulse is issued until a new START.
- R8: A STOP in the middle of a byte discards the partial byte: there is no `reg_we_o` pulse, and the pointer keeps its value.
- R9: Pulling `rst_ni` low during a transfer clears the pointer and releases SDA. Bytes clocked after the release are ignored until a new START.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: `reg_we_o` and `reg_re_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, also the external reset pin |
| scl_i | input | 1 | Synchronized, filtered SCL level |
| sda_i | input | 1 | Synchronized, filtered SDA level (wired bus value) |
| addr_strap_i | input | 1 | Strap giving the slave address LSB |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 8 | Pointer: selected register |
| reg_wdata_o | output | 8 | Write data for the register bus |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data of the register at `reg_addr_o` |
| reg_re_o | output | 1 | One-cycle read strobe, one per byte loaded |

## Verification
The hardest situations to reach are the ones in which a transfer is cut off partway through. These are a STOP after only a few data bits, an external reset between bits of a byte, and a master not-acknowledge followed by more clocking without a new START. The bench master is built from bit-level tasks, so it can stop a byte at any bit. It can then issue a STOP or pulse the reset, and keep toggling SCL afterwards to show that no acknowledge and no strobe follow. Repeated-START reads are checked against a register model in the bench, using a pointer value chosen so that its read data is asymmetric, which shows the bit order.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam logic [ADDR_W-2:0] DEV_ADDR_HI = 6'b010000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } xfer_state_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_rb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strap_i,
  output logic              match_o
);
  localparam logic [ADDR_W-2:0] HI = DEV_ADDR_HI;

  assign match_o = (addr_i == {HI, strap_i});
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_rb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              match_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  xfer_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, ptr_q, wdata_q;
  logic              rd_q, mack_q, we_q, re_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                rd_q    <= rx_q[0];
                state_q <= match_i ? ST_ADDR_ACK : ST_IDLE;
              end else if (state_q == ST_CMD) begin
                ptr_q   <= rx_q;
                state_q <= ST_CMD_ACK;
              end else begin
                wdata_q <= rx_q;
                we_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rd_q) begin
                tx_q    <= rdata_i;
                re_q    <= 1'b1;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WDATA_ACK: begin
            if (scl_fall_i) state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_LAST) begin
                cnt_q   <= '0;
                state_q <= ST_RACK;
              end else begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) mack_q <= ~sda_i;
            if (scl_fall_i) begin
              if (mack_q) begin
                tx_q    <= rdata_i;
                re_q    <= 1'b1;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_addr_o = rx_q[BYTE_W-1:1];
  assign sda_oe_o  = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK) ||
                     (state_q == ST_WDATA_ACK) ||
                     ((state_q == ST_RDATA) && !tx_q[BYTE_W-1]);
  assign ptr_o     = ptr_q;
  assign wdata_o   = wdata_q;
  assign we_o      = we_q;
  assign re_o      = re_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && re_q));
  // R11
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  // R5
  we_acked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> sda_oe_o);
  // R6
  re_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_q |-> (state_q == ST_RDATA) && (cnt_q == '0));
  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

// File: rtl/i2c_regbus_slave.sv
module i2c_regbus_slave
  import i2c_rb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              reg_re_o
);
  logic scl_rise, scl_fall, start_ev, stop_ev, match;
  logic [ADDR_W-1:0] rx_addr;

  i2c_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_addr_match u_match (
    .addr_i  (rx_addr),
    .strap_i (addr_strap_i),
    .match_o (match)
  );

  i2c_xfer_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .match_i    (match),
    .rdata_i    (reg_rdata_i),
    .rx_addr_o  (rx_addr),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o)
  );
endmodule

// File: tb/i2c_regbus_slave_tb.sv
module i2c_regbus_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_oe, we, re;
  logic [7:0] raddr, wdata, rdata;
  logic sda_bus;
  int tests = 0, fails = 0;
  int we_cnt = 0, re_cnt = 0, oe_bad = 0, strobe_bad = 0;
  logic [7:0] last_wdata = '0;
  logic oe_prev = 1'b0, scl_prev = 1'b1, we_prev = 1'b0, re_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;
  // bench register model: data for pointer p
  function automatic logic [7:0] model(input logic [7:0] p);
    return {p[3:0], ~p[7:4]};
  endfunction
  assign rdata = model(raddr);

  i2c_regbus_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_strap_i(strap), .sda_oe_o(sda_oe), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata), .reg_re_o(re)
  );

  always @(negedge clk) begin
    #1;
    if (we) begin we_cnt++; last_wdata = wdata; end
    if (re) re_cnt++;
    if ((we && re) || (we && we_prev) || (re && re_prev)) strobe_bad++;
    if (rst_n && sda_oe != oe_prev && scl_prev) oe_bad++;
    oe_prev = sda_oe; scl_prev = m_scl; we_prev = we; re_prev = re;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(4); m_scl = 1'b1; w(8); m_sda = 1'b0; w(8); m_scl = 1'b0; w(4);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(4); m_scl = 1'b1; w(8); m_sda = 1'b1; w(8);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; w(4); m_scl = 1'b1; w(8); m_scl = 1'b0; w(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; w(4); m_scl = 1'b1; w(4);
    ack = ~sda_bus;
    w(4); m_scl = 1'b0; w(4);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; w(4); m_scl = 1'b1; w(4);
      b[i] = sda_bus;
      w(4); m_scl = 1'b0; w(4);
    end
    m_sda = ~mack; w(4); m_scl = 1'b1; w(8); m_scl = 1'b0; w(4);
    m_sda = 1'b1;
  endtask

  // {strap, 7-bit address, command, data}
  localparam logic [23:0] VEC [7] = '{
    {1'b0, 7'h20, 8'h01, 8'h5A},
    {1'b1, 7'h21, 8'h03, 8'hC3},
    {1'b0, 7'h21, 8'h09, 8'h77},
    {1'b1, 7'h20, 8'h0A, 8'h12},
    {1'b0, 7'h60, 8'h0B, 8'h34},
    {1'b1, 7'h21, 8'h02, 8'hFF},
    {1'b0, 7'h20, 8'h00, 8'h00}
  };

  initial begin
    logic ack;
    logic [7:0] rb;
    int we0, re0;
    logic [7:0] ptr_before;

    w(3);
    // R1 during reset
    chk(!sda_oe && !we && !re && raddr == 8'h00, "R1 in reset", {sda_oe, we, re, raddr}, 0);
    rst_n = 1'b1; w(10);
    chk(!sda_oe && !we && !re && raddr == 8'h00, "R1 after release", {sda_oe, we, re, raddr}, 0);

    for (int v = 0; v < 7; v++) begin
      logic exp_ack;
      strap = VEC[v][23];
      exp_ack = (VEC[v][22:16] == {6'b010000, VEC[v][23]});
      ptr_before = raddr;
      we0 = we_cnt;
      bus_start();
      send_byte({VEC[v][22:16], 1'b0}, ack);
      chk(ack == exp_ack, exp_ack ? "R2 address ack" : "R3 address nack", ack, exp_ack);
      send_byte(VEC[v][15:8], ack);
      if (exp_ack) begin
        chk(ack && raddr == VEC[v][15:8], "R4 command to pointer", raddr, VEC[v][15:8]);
      end else begin
        chk(!ack && raddr == ptr_before, "R3 command ignored", raddr, ptr_before);
      end
      send_byte(VEC[v][7:0], ack);
      if (exp_ack) begin
        chk(ack && we_cnt == we0 + 1 && last_wdata == VEC[v][7:0], "R5 write data",
            last_wdata, VEC[v][7:0]);
      end else begin
        chk(!ack && we_cnt == we0, "R3 data ignored", we_cnt - we0, 0);
      end
      bus_stop();
    end

    // R5 multi-byte write keeps pointer
    strap = 1'b0;
    we0 = we_cnt;
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    send_byte(8'h07, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop();
    chk(we_cnt == we0 + 2 && last_wdata == 8'h22 && raddr == 8'h07, "R5 two writes",
        {we_cnt - we0, last_wdata, raddr}, {2, 8'h22, 8'h07});

    // R6/R7 read after repeated start
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    send_byte(8'h81, ack);
    re0 = re_cnt;
    bus_start();
    send_byte({7'h20, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    read_byte(1'b1, rb);
    chk(rb == model(8'h81), "R6 first read byte", rb, model(8'h81));
    read_byte(1'b1, rb);
    chk(rb == model(8'h81), "R7 byte after master ack", rb, model(8'h81));
    read_byte(1'b0, rb);
    chk(rb == model(8'h81) && re_cnt == re0 + 3, "R6 three read strobes", re_cnt - re0, 3);
    read_byte(1'b0, rb);
    chk(rb == 8'hFF && re_cnt == re0 + 3 && !sda_oe, "R7 released after nack",
        {rb, re_cnt - re0}, {8'hFF, 3});
    bus_stop();

    // R8 stop inside a data byte
    we0 = we_cnt;
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    send_byte(8'h05, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    chk(we_cnt == we0 && raddr == 8'h05, "R8 partial byte dropped",
        {we_cnt - we0, raddr}, {0, 8'h05});

    // R9 reset mid-transfer
    we0 = we_cnt;
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    send_byte(8'h44, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    rst_n = 1'b0; w(4);
    chk(raddr == 8'h00 && !sda_oe, "R9 reset clears pointer", raddr, 0);
    rst_n = 1'b1; w(4);
    send_byte(8'h66, ack);
    chk(!ack && we_cnt == we0 && raddr == 8'h00, "R9 ignored after reset",
        {ack, we_cnt - we0}, 0);
    bus_stop();

    chk(oe_bad == 0, "R10 sda_oe change with SCL high", oe_bad, 0);
    chk(strobe_bad == 0, "R11 strobe shape", strobe_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule